// File: doc/BRIEF.md
# 100BASE-X PCS Receive Framer

This block sits just behind the physical medium attachment. It takes one recovered code bit per bit clock and watches the idle line, which carries only ones. When a carrier appears, it locks onto the 5-bit symbol boundary that the start delimiter pair defines. It replaces that pair with two preamble nibbles, decodes each 4B/5B data symbol into a nibble, and drops the end delimiter pair. The output side behaves like a media-independent receive interface. A nibble, a valid flag and an error flag are held for one symbol period each, and a one-clock strobe marks the first bit clock of every new nibble.

Four named states make up the controller. ST_IDLE clears the outputs. The first zero bit moves it to ST_HUNT. ST_HUNT collects the seven bits that follow that zero and then judges the 10-bit window that opens two bits before it. With fewer than two zeros in the window it goes back to ST_IDLE (noise). With the delimiter pair it moves to ST_RECV. With any other content it moves to ST_FALSE. ST_RECV counts five bits per symbol. At every symbol boundary it looks at the last two symbols. A T/R pair or a run of two IDLE symbols returns it to ST_IDLE; anything else keeps it in ST_RECV. ST_FALSE holds the false-carrier indication until a run of QUIET_LEN consecutive ones has arrived, and then returns to ST_IDLE. A sticky premature-end flag records streams that stop without a proper end delimiter. A software agent clears that flag through a pulse input.

Top module: `pcs_rx_framer`

## Requirements
- R1: While the line carries ones and no stream is active, rxd is 0000 and rx_dv, rx_er and nib_stb are low. Whenever rx_dv and rx_er are both low, rxd is 0000.
- R2: A zero is ignored, with no output change, if the 10-bit window is fewer than two zeros. That window starts two bits before the zero and ends seven bits after it.
- R3: Code groups are written first bit leftmost: J=11000, K=10001, T=01101, R=00111, IDLE=11111. When the window equals J followed by K, rx_dv rises with rxd=0101 and a strobe in the clock that takes the last K bit. A second 0101 nibble follows one symbol (five clocks) later.
- R4: Data symbols use this table, nibble 0 to F in order: 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101. Each nibble appears, with rx_dv high and rx_er low, at the boundary where the following symbol completes. It is held for five clocks, and nib_stb pulses only in the first of them.
- R5: A T symbol directly followed by an R symbol ends the stream. Neither symbol is presented. At the boundary where R completes, rx_dv and rx_er go low with rxd=0000, and hunting resumes.
- R6: Some symbols are not in the data table or are out of place, such as J, K, a lone IDLE, or a T not followed by R. In that symbol's slot, rx_dv and rx_er are high with rxd=0000, and reception continues with the next symbol.
- R7: Two IDLE symbols in a row on the symbol boundary during a stream end it prematurely. rx_er and rx_dv are high with rxd=0000 for one clock, prem_end is set, and the block returns to idle.
- R8: Once set, prem_end stays high until clr_prem is sampled high. It then reads low from the next clock, unless a premature end is recognised in that same clock, in which case setting wins.
- R9: A window with two or more zeros that is not J/K is a false carrier. rx_er goes high with rxd=1110 and rx_dv low, and this holds until QUIET_LEN consecutive ones have arrived. Outputs clear in the clock that takes the last of those ones.
- R10: While rst_n is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_bit | input | 1 | Recovered code bit, one per clock |
| clr_prem | input | 1 | Clears the sticky premature-end flag |
| rxd | output | 4 | Received nibble |
| rx_dv | output | 1 | Nibble carries frame data or preamble |
| rx_er | output | 1 | Receive error or false carrier |
| nib_stb | output | 1 | One-clock pulse at the start of each new nibble period |
| prem_end | output | 1 | Sticky premature-end status |

## Verification
The bench builds the block with QUIET_LEN at its default of 10. That value lets a single false-carrier burst run all the way through its exit window inside a short idle gap. It also keeps the exit count of ones close to the width of the delimiter window, so an off-by-one in the quiet counter moves the exit by a clock the model detects. The streams exercise every data code, a lone noise zero, an invalid code, a T not followed by R, and a stream cut short by idles while clear is held.

// File: rtl/pcs_rx_pkg.sv
package pcs_rx_pkg;

    localparam int SYM_W = 5;
    localparam int NIB_W = 4;

    localparam logic [SYM_W-1:0] CG_J    = 5'b11000;
    localparam logic [SYM_W-1:0] CG_K    = 5'b10001;
    localparam logic [SYM_W-1:0] CG_T    = 5'b01101;
    localparam logic [SYM_W-1:0] CG_R    = 5'b00111;
    localparam logic [SYM_W-1:0] CG_IDLE = 5'b11111;

    localparam logic [NIB_W-1:0] PRE_NIB = 4'b0101;
    localparam logic [NIB_W-1:0] FC_NIB  = 4'b1110;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HUNT,
        ST_FALSE,
        ST_RECV
    } rx_state_e;

endpackage

// File: rtl/pcs_rx_window.sv
module pcs_rx_window #(
    parameter int WIN_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_in,
    output logic [WIN_W-1:0] win_o
);

    logic [WIN_W-2:0] hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '1;
        end else begin
            hist_q <= {hist_q[WIN_W-3:0], bit_in};
        end
    end

    // newest bit sits in the LSB, oldest in the MSB
    assign win_o = {hist_q, bit_in};

endmodule

// File: rtl/pcs_rx_symdec.sv
module pcs_rx_symdec
    import pcs_rx_pkg::*;
(
    input  logic [SYM_W-1:0] code_i,
    output logic             valid_o,
    output logic [NIB_W-1:0] nib_o
);

    always_comb begin
        valid_o = 1'b1;
        nib_o   = '0;
        unique case (code_i)
            5'b11110: nib_o = 4'h0;
            5'b01001: nib_o = 4'h1;
            5'b10100: nib_o = 4'h2;
            5'b10101: nib_o = 4'h3;
            5'b01010: nib_o = 4'h4;
            5'b01011: nib_o = 4'h5;
            5'b01110: nib_o = 4'h6;
            5'b01111: nib_o = 4'h7;
            5'b10010: nib_o = 4'h8;
            5'b10011: nib_o = 4'h9;
            5'b10110: nib_o = 4'hA;
            5'b10111: nib_o = 4'hB;
            5'b11010: nib_o = 4'hC;
            5'b11011: nib_o = 4'hD;
            5'b11100: nib_o = 4'hE;
            5'b11101: nib_o = 4'hF;
            default:  valid_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/pcs_rx_framer.sv
module pcs_rx_framer
    import pcs_rx_pkg::*;
#(
    parameter int QUIET_LEN = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_bit,
    input  logic       clr_prem,
    output logic [3:0] rxd,
    output logic       rx_dv,
    output logic       rx_er,
    output logic       nib_stb,
    output logic       prem_end
);

    localparam int WIN_W     = 2 * SYM_W;
    localparam int CW        = $clog2(WIN_W);
    localparam int QW        = $clog2(QUIET_LEN + 1);
    localparam int HUNT_LAST = WIN_W - 4;
    localparam int SYM_LAST  = SYM_W - 1;

    logic [WIN_W-1:0] win;
    logic [SYM_W-1:0] prev_sym, cur_sym;
    logic             prev_ok;
    logic [NIB_W-1:0] prev_nib;
    logic [CW:0]      zero_cnt;

    pcs_rx_window #(.WIN_W(WIN_W)) u_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .bit_in (rx_bit),
        .win_o  (win)
    );

    assign prev_sym = win[WIN_W-1:SYM_W];
    assign cur_sym  = win[SYM_W-1:0];
    assign zero_cnt = (CW+1)'($countones(~win));

    pcs_rx_symdec u_dec (
        .code_i  (prev_sym),
        .valid_o (prev_ok),
        .nib_o   (prev_nib)
    );

    rx_state_e        st_q, st_d;
    logic [CW-1:0]    cnt_q, cnt_d;
    logic [QW-1:0]    qc_q, qc_d;
    logic             first_q, first_d;
    logic [NIB_W-1:0] rxd_d;
    logic             dv_d, er_d, stb_d, prem_set;

    always_comb begin
        st_d     = st_q;
        cnt_d    = cnt_q;
        qc_d     = qc_q;
        first_d  = first_q;
        rxd_d    = rxd;
        dv_d     = rx_dv;
        er_d     = rx_er;
        stb_d    = 1'b0;
        prem_set = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                rxd_d = '0;
                dv_d  = 1'b0;
                er_d  = 1'b0;
                cnt_d = '0;
                if (!rx_bit) st_d = ST_HUNT;
            end
            ST_HUNT: begin
                rxd_d = '0;
                dv_d  = 1'b0;
                er_d  = 1'b0;
                if (cnt_q == CW'(HUNT_LAST)) begin
                    cnt_d = '0;
                    if (zero_cnt < (CW+1)'(2)) begin
                        st_d = ST_IDLE;
                    end else if (win == {CG_J, CG_K}) begin
                        rxd_d   = PRE_NIB;
                        dv_d    = 1'b1;
                        stb_d   = 1'b1;
                        first_d = 1'b1;
                        st_d    = ST_RECV;
                    end else begin
                        rxd_d = FC_NIB;
                        er_d  = 1'b1;
                        stb_d = 1'b1;
                        qc_d  = '0;
                        st_d  = ST_FALSE;
                    end
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_FALSE: begin
                if (!rx_bit) begin
                    qc_d = '0;
                end else if (qc_q == QW'(QUIET_LEN - 1)) begin
                    rxd_d = '0;
                    er_d  = 1'b0;
                    st_d  = ST_IDLE;
                end else begin
                    qc_d = qc_q + 1'b1;
                end
            end
            ST_RECV: begin
                if (cnt_q == CW'(SYM_LAST)) begin
                    cnt_d = '0;
                    stb_d = 1'b1;
                    if (first_q) begin
                        first_d = 1'b0;
                        rxd_d   = PRE_NIB;
                        dv_d    = 1'b1;
                        er_d    = 1'b0;
                    end else if (prev_sym == CG_T && cur_sym == CG_R) begin
                        rxd_d = '0;
                        dv_d  = 1'b0;
                        er_d  = 1'b0;
                        st_d  = ST_IDLE;
                    end else if (prev_sym == CG_IDLE && cur_sym == CG_IDLE) begin
                        rxd_d    = '0;
                        dv_d     = 1'b1;
                        er_d     = 1'b1;
                        prem_set = 1'b1;
                        st_d     = ST_IDLE;
                    end else if (prev_ok) begin
                        rxd_d = prev_nib;
                        dv_d  = 1'b1;
                        er_d  = 1'b0;
                    end else begin
                        rxd_d = '0;
                        dv_d  = 1'b1;
                        er_d  = 1'b1;
                    end
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            cnt_q   <= '0;
            qc_q    <= '0;
            first_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            cnt_q   <= cnt_d;
            qc_q    <= qc_d;
            first_q <= first_d;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rxd      <= '0;
            rx_dv    <= 1'b0;
            rx_er    <= 1'b0;
            nib_stb  <= 1'b0;
            prem_end <= 1'b0;
        end else begin
            rxd     <= rxd_d;
            rx_dv   <= dv_d;
            rx_er   <= er_d;
            nib_stb <= stb_d;
            if (prem_set)      prem_end <= 1'b1;
            else if (clr_prem) prem_end <= 1'b0;
        end
    end

endmodule

// File: rtl/pcs_rx_chk.sv
module pcs_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       clr_prem,
    input logic [3:0] rxd,
    input logic       rx_dv,
    input logic       rx_er,
    input logic       nib_stb,
    input logic       prem_end
);

    // R3
    pre_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_dv) |-> (rxd == 4'b0101 && nib_stb));

    // R9
    fc_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_er && !rx_dv) |-> (rxd == 4'b1110));

    // R8
    prem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prem_end && !clr_prem) |=> prem_end);

    // R4
    nib_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_dv && !nib_stb && $past(rx_dv)) |-> $stable(rxd));

    // R4
    stb_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nib_stb |=> !nib_stb);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_dv && !rx_er) |-> (rxd == 4'b0000));

endmodule

bind pcs_rx_framer pcs_rx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_prem (clr_prem),
    .rxd      (rxd),
    .rx_dv    (rx_dv),
    .rx_er    (rx_er),
    .nib_stb  (nib_stb),
    .prem_end (prem_end)
);

// File: tb/pcs_rx_framer_tb.sv
module pcs_rx_framer_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_bit = 1'b1;
    logic       clr_prem = 1'b0;
    logic [3:0] rxd;
    logic       rx_dv, rx_er, nib_stb, prem_end;

    int errs = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pcs_rx_framer #(.QUIET_LEN(10)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .clr_prem(clr_prem),
        .rxd(rxd), .rx_dv(rx_dv), .rx_er(rx_er), .nib_stb(nib_stb), .prem_end(prem_end)
    );

    localparam logic [4:0] DTAB [16] = '{
        5'b11110, 5'b01001, 5'b10100, 5'b10101, 5'b01010, 5'b01011, 5'b01110, 5'b01111,
        5'b10010, 5'b10011, 5'b10110, 5'b10111, 5'b11010, 5'b11011, 5'b11100, 5'b11101};
    localparam logic [4:0] J_C = 5'b11000, K_C = 5'b10001, T_C = 5'b01101,
                           R_C = 5'b00111, I_C = 5'b11111;

    // behavioural reference model
    bit  hist [$];
    int  mode = 0;      // 0 quiet, 1 judging, 2 false carrier, 3 in frame
    int  since = 0;
    int  ones_run = 0;
    bit  pre_left = 0;
    logic [3:0] e_rxd = 4'h0;
    bit  e_dv = 0, e_er = 0, e_stb = 0, e_prem = 0;
    string e_tag = "R10";

    function automatic int count_zeros(int last_n);
        int z = 0;
        for (int i = hist.size() - last_n; i < hist.size(); i++) if (!hist[i]) z++;
        return z;
    endfunction

    function automatic logic [4:0] sym_at(int back);
        logic [4:0] s;
        for (int i = 0; i < 5; i++) s[4-i] = hist[hist.size() - back - 5 + i];
        return s;
    endfunction

    function automatic int lookup(logic [4:0] c);
        for (int i = 0; i < 16; i++) if (DTAB[i] == c) return i;
        return -1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            hist.delete();
            for (int i = 0; i < 12; i++) hist.push_back(1'b1);
            mode = 0; e_rxd = 0; e_dv = 0; e_er = 0; e_stb = 0; e_prem = 0;
        end else begin
            hist.push_back(rx_bit);
            if (hist.size() > 40) void'(hist.pop_front());
            e_stb = 0;
            if (clr_prem) e_prem = 0;
            if (mode == 0) begin
                e_rxd = 0; e_dv = 0; e_er = 0; e_tag = "R1";
                if (!rx_bit) begin mode = 1; since = 0; end
            end else if (mode == 1) begin
                e_rxd = 0; e_dv = 0; e_er = 0; e_tag = "R2";
                since++;
                if (since == 7) begin
                    if (count_zeros(10) < 2) mode = 0;
                    else if (sym_at(5) == J_C && sym_at(0) == K_C) begin
                        e_rxd = 4'b0101; e_dv = 1; e_stb = 1; pre_left = 1;
                        mode = 3; since = 0; e_tag = "R3";
                    end else begin
                        e_rxd = 4'b1110; e_er = 1; e_stb = 1; ones_run = 0;
                        mode = 2; e_tag = "R9";
                    end
                end
            end else if (mode == 2) begin
                e_tag = "R9";
                ones_run = rx_bit ? ones_run + 1 : 0;
                if (ones_run == 10) begin e_rxd = 0; e_er = 0; mode = 0; end
            end else begin
                since++;
                if (since == 5) begin
                    logic [4:0] p, c;
                    since = 0; e_stb = 1;
                    p = sym_at(5); c = sym_at(0);
                    if (pre_left) begin
                        pre_left = 0; e_rxd = 4'b0101; e_dv = 1; e_er = 0; e_tag = "R3";
                    end else if (p == T_C && c == R_C) begin
                        e_rxd = 0; e_dv = 0; e_er = 0; mode = 0; e_tag = "R5";
                    end else if (p == I_C && c == I_C) begin
                        e_rxd = 0; e_dv = 1; e_er = 1; e_prem = 1; mode = 0; e_tag = "R7";
                    end else if (lookup(p) >= 0) begin
                        e_rxd = 4'(lookup(p)); e_dv = 1; e_er = 0; e_tag = "R4";
                    end else begin
                        e_rxd = 0; e_dv = 1; e_er = 1; e_tag = "R6";
                    end
                end
            end
        end
    end

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(e_tag, {rxd, rx_dv, rx_er, nib_stb, prem_end},
                       {e_rxd, e_dv, e_er, e_stb, e_prem});
        end
    end

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            errs++;
            $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
            finish_run();
        end
    end

    task automatic send_bit(bit b);
        @(negedge clk);
        rx_bit = b;
    endtask

    task automatic send_ones(int n);
        for (int i = 0; i < n; i++) send_bit(1'b1);
    endtask

    task automatic send_code(logic [4:0] c);
        for (int i = 4; i >= 0; i--) send_bit(c[i]);
    endtask

    initial begin
        #5;
        // R10: outputs during reset
        chk("R10", {rxd, rx_dv, rx_er, nib_stb, prem_end}, 8'h00);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        send_ones(20);

        // R2: single noise zero
        send_bit(1'b0);
        send_ones(20);

        // R3 R4 R5: frame carrying every data code
        send_code(J_C); send_code(K_C);
        for (int d = 0; d < 16; d++) send_code(DTAB[d]);
        send_code(T_C); send_code(R_C);
        send_ones(15);

        // R6: invalid code and misplaced J inside a frame
        send_code(J_C); send_code(K_C);
        send_code(DTAB[5]); send_code(5'b00000); send_code(DTAB[10]);
        send_code(J_C); send_code(DTAB[3]);
        send_code(T_C); send_code(R_C);
        send_ones(15);

        // R6: T not followed by R
        send_code(J_C); send_code(K_C);
        send_code(DTAB[9]); send_code(T_C); send_code(DTAB[6]);
        send_code(T_C); send_code(R_C);
        send_ones(15);

        // R7: premature end by idles
        send_code(J_C); send_code(K_C);
        send_code(DTAB[3]); send_code(DTAB[7]);
        send_ones(20);
        @(negedge clk);
        chk("R7", {7'h0, prem_end}, 8'h01);
        // R8: flag stays until cleared
        send_ones(10);
        chk("R8", {7'h0, prem_end}, 8'h01);
        clr_prem = 1'b1;
        @(negedge clk);
        clr_prem = 1'b0;
        chk("R8", {7'h0, prem_end}, 8'h00);

        // R9: false carrier
        send_ones(5);
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        send_ones(25);

        // R8: set while clear is held high
        clr_prem = 1'b1;
        send_code(J_C); send_code(K_C);
        send_code(DTAB[12]);
        send_ones(11);
        @(negedge clk);
        clr_prem = 1'b0;
        send_ones(15);

        // R1: quiet line after everything
        send_ones(10);
        chk("R1", {rxd, rx_dv, rx_er, nib_stb}, 8'h00);
        finish_run();
    end

endmodule